// File: doc/BRIEF.md
# S-box Feedback Traversal Self-Test Sequencer

This block runs a short, deterministic self-test of an 8-bit AES byte substitution unit. It does not drive the substitution input with random rounds. Instead it closes a loop: the substitution output passes through a fixed XOR with 0x76 and is registered back to the input. This loop steps through every one of the 256 byte values in 256 consecutive cycles. Without the XOR, the plain substitution loop would break into several short cycles and could not reach every value in one pass.

A second, optional phase follows. It applies 16 fixed byte patterns to exercise the logic that surrounds the substitution unit. Every substitution response from both phases is folded into an 8-bit multiple-input signature register. When the run ends, `done_o` rises. `done_o` and the signature then stay unchanged until the next accepted start, so a host can compare the signature with a golden value at leisure.

Top module: `sbt_selftest`

## Requirements
- R1: After reset, `state_o` is 0x00, `sig_o` is 0x00 and `done_o` is 0.
- R2: When start is accepted, the next cycle shows `state_o` = 0x00. In each later cycle of phase one, `state_o` becomes sub(previous) XOR 0x76, where sub is the AES forward byte substitution and sub(0x00) = 0x63.
- R3: The 256 values shown on `state_o` during phase one are pairwise distinct, so they cover every byte value.
- R4: With `mode_i` = 0 at start, phase one is followed by 16 cycles in which `state_o` = {k[3:0], ~k[3:0]} for k = 0..15.
- R5: `done_o` rises exactly 272 cycles after the accepted start edge when `mode_i` = 0, and 256 cycles after it when `mode_i` = 1. It stays low during the whole run.
- R6: The signature starts from 0x00. Each cycle of the run updates it as s' = {s[6:0],0} XOR (s[7] ? 0x1B : 0x00) XOR sub(`state_o`), which is the polynomial x^8+x^4+x^3+x+1.
- R7: While `done_o` is high and no start is given, `done_o` and `sig_o` hold their values.
- R8: A start pulse during a run is ignored and the sequence continues unchanged. A start pulse after done restarts the run from the beginning with a cleared signature.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a run when idle or done |
| mode_i | input | 1 | Sampled at start: 0 runs both phases, 1 runs the substitution phase only |
| state_o | output | 8 | Byte currently applied to the substitution unit |
| sig_o | output | 8 | Signature register contents |
| done_o | output | 1 | Run finished; held until the next start |

## Verification
On every cycle the assertions check several properties: the phase-two pattern follows its step count, the run lasts 256 or 272 cycles, `done_o` and the signature stay fixed after completion, and an accepted start clears the state and the signature. The bench scenarios cover what needs a full reference model. They compare the exact substitution-feedback sequence against a model, confirm that all 256 values appear in phase one, and check the final signature in both modes. They also check that a start pulse in the middle of a run leaves the sequence untouched.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SBOX  = 2'd1,
        PH_LOGIC = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    localparam byte_t FB_CONST   = 8'h76;
    localparam byte_t MISR_POLY  = 8'h1B;
    localparam byte_t MISR_SEED  = 8'h00;
    localparam byte_t LOOP_SEED  = 8'h00;
    localparam byte_t AFF_CONST  = 8'h63;

    // GF(2^8) product modulo x^8+x^4+x^3+x+1
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t aa;
        acc = '0;
        aa  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ aa;
            aa = aa[7] ? ({aa[6:0], 1'b0} ^ 8'h1B) : {aa[6:0], 1'b0};
        end
        return acc;
    endfunction

    // Multiplicative inverse as a^254; maps 0 to 0
    function automatic byte_t gf_inv(input byte_t a);
        byte_t pw;
        byte_t res;
        pw  = a;
        res = 8'h01;
        for (int i = 1; i < BYTE_W; i++) begin
            pw  = gf_mul(pw, pw);
            res = gf_mul(res, pw);
        end
        return res;
    endfunction

    function automatic byte_t rotl(input byte_t v, input int n);
        return byte_t'((v << n) | (v >> (BYTE_W - n)));
    endfunction

    function automatic byte_t sub_byte(input byte_t a);
        byte_t b;
        b = gf_inv(a);
        return b ^ rotl(b, 1) ^ rotl(b, 2) ^ rotl(b, 3) ^ rotl(b, 4) ^ AFF_CONST;
    endfunction

    function automatic byte_t misr_next(input byte_t s, input byte_t d);
        return ({s[6:0], 1'b0} ^ (s[7] ? MISR_POLY : '0)) ^ d;
    endfunction

    function automatic byte_t logic_pat(input logic [3:0] k);
        return {k, ~k};
    endfunction

endpackage

// File: rtl/sbt_sbox.sv
module sbt_sbox
    import sbt_pkg::*;
(
    input  byte_t din,
    output byte_t dout
);
    always_comb dout = sub_byte(din);
endmodule

// File: rtl/sbt_misr.sv
module sbt_misr
    import sbt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  absorb,
    input  byte_t din,
    output byte_t sig
);
    byte_t sig_q;

    always_ff @(posedge clk) begin
        if (rst || clear) sig_q <= MISR_SEED;
        else if (absorb)  sig_q <= misr_next(sig_q, din);
    end

    assign sig = sig_q;
endmodule

// File: rtl/sbt_selftest.sv
module sbt_selftest
    import sbt_pkg::*;
#(
    parameter int SBOX_CYCLES  = 256,
    parameter int LOGIC_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       mode_i,
    output logic [7:0] state_o,
    output logic [7:0] sig_o,
    output logic       done_o
);
    localparam int CNT_W      = $clog2(SBOX_CYCLES);
    localparam int SBOX_LAST  = SBOX_CYCLES - 1;
    localparam int LOGIC_LAST = LOGIC_CYCLES - 1;

    phase_e            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    byte_t             state_q;
    logic              short_q;
    byte_t             sub_out;
    logic              accept;
    logic              busy;
    logic [3:0]        pat_idx;

    assign busy    = (phase_q == PH_SBOX) || (phase_q == PH_LOGIC);
    assign accept  = start_i && !busy;
    assign pat_idx = cnt_q[3:0] + 4'd1;

    sbt_sbox u_sbox (
        .din  (state_q),
        .dout (sub_out)
    );

    sbt_misr u_misr (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept),
        .absorb (busy),
        .din    (sub_out),
        .sig    (sig_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            state_q <= LOOP_SEED;
            short_q <= 1'b0;
        end else begin
            case (phase_q)
                PH_SBOX: begin
                    if (cnt_q == CNT_W'(SBOX_LAST)) begin
                        cnt_q <= '0;
                        if (short_q) begin
                            phase_q <= PH_DONE;
                            state_q <= sub_out ^ FB_CONST;
                        end else begin
                            phase_q <= PH_LOGIC;
                            state_q <= logic_pat(4'd0);
                        end
                    end else begin
                        cnt_q   <= cnt_q + 1'b1;
                        state_q <= sub_out ^ FB_CONST;
                    end
                end
                PH_LOGIC: begin
                    if (cnt_q == CNT_W'(LOGIC_LAST)) begin
                        phase_q <= PH_DONE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q   <= cnt_q + 1'b1;
                        state_q <= logic_pat(pat_idx);
                    end
                end
                default: begin
                    if (start_i) begin
                        phase_q <= PH_SBOX;
                        cnt_q   <= '0;
                        state_q <= LOOP_SEED;
                        short_q <= mode_i;
                    end
                end
            endcase
        end
    end

    assign state_o = state_q;
    assign done_o  = (phase_q == PH_DONE);

endmodule

// File: rtl/sbt_selftest_chk.sv
module sbt_selftest_chk
    import sbt_pkg::*;
#(
    parameter int SBOX_CYCLES  = 256,
    parameter int LOGIC_CYCLES = 16,
    parameter int CNT_W        = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [7:0]       state_o,
    input logic [7:0]       sig_o,
    input logic             done_o,
    input phase_e           phase_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             short_q
);
    logic        is_busy;
    logic [15:0] run_cnt;

    assign is_busy = (phase_q == PH_SBOX) || (phase_q == PH_LOGIC);

    always_ff @(posedge clk) begin
        if (rst)                      run_cnt <= '0;
        else if (start_i && !is_busy) run_cnt <= '0;
        else if (is_busy)             run_cnt <= run_cnt + 16'd1;
    end

    // R5: run length up to done
    a_r5_run_length: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> (run_cnt == (short_q ? 16'(SBOX_CYCLES)
                                               : 16'(SBOX_CYCLES + LOGIC_CYCLES))));

    // R7: done held without start
    a_r7_done_held: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o);

    // R7: signature held without start
    a_r7_sig_held: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> $stable(sig_o));

    // R8: accepted start clears the loop and signature
    a_r8_start_clears: assert property (@(posedge clk) disable iff (rst)
        (start_i && !is_busy) |=> (state_o == 8'h00 && sig_o == 8'h00 && !done_o));

    // R4: phase-two pattern tracks the step count
    a_r4_logic_pattern: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_LOGIC) |-> (state_o == {cnt_q[3:0], ~cnt_q[3:0]}));

    // R5: done never high while running
    a_r5_no_done_busy: assert property (@(posedge clk) disable iff (rst)
        is_busy |-> !done_o);
endmodule

bind sbt_selftest sbt_selftest_chk #(
    .SBOX_CYCLES  (SBOX_CYCLES),
    .LOGIC_CYCLES (LOGIC_CYCLES),
    .CNT_W        (CNT_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .state_o (state_o),
    .sig_o   (sig_o),
    .done_o  (done_o),
    .phase_q (phase_q),
    .cnt_q   (cnt_q),
    .short_q (short_q)
);

// File: tb/sbt_selftest_bench.sv
module sbt_selftest_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       mode_i = 1'b0;
    logic [7:0] state_o;
    logic [7:0] sig_o;
    logic       done_o;

    int total = 0;
    int bad   = 0;
    bit mon_en = 1'b0;
    bit ph1_track = 1'b0;
    int seen_cnt [256];
    logic [7:0] exp_q [$];
    int phase1_left = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbt_selftest u_sbt_selftest (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .mode_i  (mode_i),
        .state_o (state_o),
        .sig_o   (sig_o),
        .done_o  (done_o)
    );

    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] m_sub(input logic [7:0] x);
        logic [7:0] inv = 8'h00;
        logic [7:0] r;
        logic [7:0] c = 8'h63;
        for (int y = 1; y < 256; y++) if (m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
        for (int i = 0; i < 8; i++)
            r[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
        return r;
    endfunction

    function automatic logic [7:0] m_misr(input logic [7:0] s, input logic [7:0] d);
        logic [7:0] t = {s[6:0], 1'b0};
        if (s[7]) t = t ^ 8'h1B;
        return t ^ d;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected states and compares
    always @(negedge clk) begin
        if (mon_en && exp_q.size() > 0) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(state_o == e, "R2/R4 state", state_o, e);
            check(done_o == 1'b0, "R5 done low in run", done_o, 0);
            if (ph1_track && phase1_left > 0) begin
                seen_cnt[state_o]++;
                phase1_left--;
            end
        end
    end

    // driver: builds expectations, starts run, checks completion
    task automatic run_test(input bit short_mode, input bit poke_mid);
        logic [7:0] x = 8'h00;
        logic [7:0] sig = 8'h00;
        int distinct = 0;
        for (int i = 0; i < 256; i++) seen_cnt[i] = 0;
        for (int i = 0; i < 256; i++) begin
            exp_q.push_back(x);
            sig = m_misr(sig, m_sub(x));
            x = m_sub(x) ^ 8'h76;
        end
        if (!short_mode) begin
            for (int k = 0; k < 16; k++) begin
                logic [3:0] kk = 4'(k);
                exp_q.push_back({kk, ~kk});
                sig = m_misr(sig, m_sub({kk, ~kk}));
            end
        end
        phase1_left = 256;
        ph1_track = 1'b1;
        @(negedge clk);
        mode_i = short_mode;
        start_i = 1'b1;
        @(posedge clk);
        #1;
        start_i = 1'b0;
        mode_i = ~short_mode;
        mon_en = 1'b1;
        if (poke_mid) begin
            repeat (40) @(negedge clk);
            start_i = 1'b1;   // R8: ignored while running
            @(negedge clk);
            start_i = 1'b0;
        end
        wait (exp_q.size() == 0);
        @(negedge clk);
        mon_en = 1'b0;
        ph1_track = 1'b0;
        check(done_o == 1'b1, "R5 done at end", done_o, 1);
        check(sig_o == sig, "R6 signature", sig_o, sig);
        for (int i = 0; i < 256; i++) if (seen_cnt[i] == 1) distinct++;
        check(distinct == 256, "R3 all values once", distinct, 256);
        repeat (7) @(negedge clk);
        check(done_o == 1'b1, "R7 done held", done_o, 1);
        check(sig_o == sig, "R7 sig held", sig_o, sig);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(state_o == 8'h00, "R1 reset state", state_o, 0);
        check(sig_o == 8'h00, "R1 reset sig", sig_o, 0);
        check(done_o == 1'b0, "R1 reset done", done_o, 0);
        check(m_sub(8'h00) == 8'h63, "R2 model sub(0)", m_sub(8'h00), 8'h63);
        run_test(1'b0, 1'b0);   // R4 R5 full run
        run_test(1'b1, 1'b0);   // R5 short run, R8 restart
        run_test(1'b0, 1'b1);   // R8 mid-run start ignored
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule